// File: doc/BRIEF.md
# Two-Lap Forwarding Range Selector

This block sits beside a circular store queue of `N` entries. Every queue pointer is an index plus a one-bit lap flag that toggles each time the pointer wraps. The block takes the oldest (dequeue) pointer and the position of a load in program order, the query pointer. It returns two `N`-bit masks that together mark every store older than the load. The first mask holds the entries in the dequeue pointer's lap. The second holds the entries in the lap after it.

The block also takes a per-entry hit vector, which a separate address comparison produces. From the hits that fall inside the selected range, it reports the youngest one. A hit in the later lap always beats a hit in the earlier lap. Inside one lap, the higher index is younger.

The logic is combinational. A parameter can add one register stage on all outputs.

Top module: `sq_lap_range`

## Requirements
- R1: When the two lap flags are equal, `lap0_mask` bit i is 1 exactly when `deq_idx <= i < qry_idx`, and `lap1_mask` is all zeros.
- R2: When the lap flags are equal and `qry_idx == deq_idx`, both masks are all zeros, because the range is empty.
- R3: When the lap flags differ, `lap0_mask` bit i is 1 exactly when `i >= deq_idx`, and `lap1_mask` bit i is 1 exactly when `i < qry_idx`.
- R4: `young_vld` is 1 exactly when `hit_vec & (lap0_mask | lap1_mask)` is nonzero. When it is 1, `young_idx` names an entry that is both hit and selected.
- R5: If any bit of `hit_vec & lap1_mask` is set, `young_idx` is the highest such index, even when a higher-indexed hit exists in `lap0_mask`.
- R6: If no selected hit lies in `lap1_mask`, `young_idx` is the highest index set in `hit_vec & lap0_mask`.
- R7: With `REG_OUT = 1`, every output shows the result for the inputs present at the previous rising clock edge, and all outputs are zero while `rst_n` is low. With `REG_OUT = 0`, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when REG_OUT = 1 |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| deq_idx | input | $clog2(N) | Index of the oldest queue entry |
| deq_wrap | input | 1 | Lap flag of the dequeue pointer |
| qry_idx | input | $clog2(N) | Index at which the load sits in program order |
| qry_wrap | input | 1 | Lap flag of the query pointer |
| hit_vec | input | N | Per-entry match vector |
| lap0_mask | output | N | Selected entries in the dequeue pointer's lap |
| lap1_mask | output | N | Selected entries in the following lap |
| young_vld | output | 1 | A selected entry matched |
| young_idx | output | $clog2(N) | Index of the youngest selected matching entry |

## Verification
The hardest case to reach needs three things at once: the lap flags differ, and hits sit in both laps, with the earlier-lap hit at a higher index than the later-lap hit. Random stimulus alone seldom produces this. The stimulus therefore includes directed vectors with `deq_idx` near the top, `qry_idx` near the bottom, and hits placed on both sides of the wrap point.

Random vectors use a dense hit vector, so that every selection is heavily contested. The empty range and the full range are driven explicitly.

// File: rtl/sq_lap_range.sv
module sq_lap_range #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b0,
  localparam int IW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] deq_idx,
  input  logic          deq_wrap,
  input  logic [IW-1:0] qry_idx,
  input  logic          qry_wrap,
  input  logic [N-1:0]  hit_vec,
  output logic [N-1:0]  lap0_mask,
  output logic [N-1:0]  lap1_mask,
  output logic          young_vld,
  output logic [IW-1:0] young_idx
);

  function automatic logic [IW:0] top_set(input logic [N-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (v[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  logic          same_lap;
  logic [N-1:0]  at_or_above_deq, below_qry;
  logic [N-1:0]  m0, m1;
  logic [IW:0]   sel0, sel1;
  logic          vld_c;
  logic [IW-1:0] idx_c;

  assign same_lap = deq_wrap == qry_wrap;

  for (genvar i = 0; i < N; i++) begin : g_bound
    assign at_or_above_deq[i] = IW'(i) >= deq_idx;
    assign below_qry[i]       = IW'(i) <  qry_idx;
  end

  assign m0 = same_lap ? (at_or_above_deq & below_qry) : at_or_above_deq;
  assign m1 = same_lap ? '0 : below_qry;

  assign sel1  = top_set(hit_vec & m1);
  assign sel0  = top_set(hit_vec & m0);
  assign vld_c = sel1[IW] | sel0[IW];
  assign idx_c = sel1[IW] ? sel1[IW-1:0] : sel0[IW-1:0];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lap0_mask <= '0;
        lap1_mask <= '0;
        young_vld <= 1'b0;
        young_idx <= '0;
      end else begin
        lap0_mask <= m0;
        lap1_mask <= m1;
        young_vld <= vld_c;
        young_idx <= idx_c;
      end
    end
  end else begin : g_comb
    assign lap0_mask = m0;
    assign lap1_mask = m1;
    assign young_vld = vld_c;
    assign young_idx = idx_c;
  end

endmodule

// File: rtl/sq_lap_range_chk.sv
module sq_lap_range_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b0,
  localparam int IW     = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] deq_idx,
  input logic          deq_wrap,
  input logic [IW-1:0] qry_idx,
  input logic          qry_wrap,
  input logic [N-1:0]  hit_vec,
  input logic [N-1:0]  lap0_mask,
  input logic [N-1:0]  lap1_mask,
  input logic          young_vld,
  input logic [IW-1:0] young_idx
);

  logic [IW-1:0] di, qi;
  logic          dw, qw;
  logic [N-1:0]  hv;

  if (REG_OUT) begin : g_view_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        di <= '0; qi <= '0; dw <= 1'b0; qw <= 1'b0; hv <= '0;
      end else begin
        di <= deq_idx; qi <= qry_idx; dw <= deq_wrap; qw <= qry_wrap; hv <= hit_vec;
      end
    end
  end else begin : g_view_comb
    assign di = deq_idx;
    assign qi = qry_idx;
    assign dw = deq_wrap;
    assign qw = qry_wrap;
    assign hv = hit_vec;
  end

  a_r1_second_lap_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (dw == qw) |-> (lap1_mask == '0));

  a_r2_empty_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dw == qw && di == qi) |-> (lap0_mask == '0));

  a_r3_first_lap_reaches_top: assert property (@(posedge clk) disable iff (!rst_n)
    (dw != qw) |-> lap0_mask[N-1]);

  a_r4_hit_is_selected: assert property (@(posedge clk) disable iff (!rst_n)
    young_vld |-> (hv[young_idx] && (lap0_mask[young_idx] || lap1_mask[young_idx])));

  a_r4_none_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !young_vld |-> ((hv & (lap0_mask | lap1_mask)) == '0));

  a_r5_later_lap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((hv & lap1_mask) != '0) |-> (young_vld && lap1_mask[young_idx]));

endmodule

bind sq_lap_range sq_lap_range_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .deq_idx(deq_idx), .deq_wrap(deq_wrap),
  .qry_idx(qry_idx), .qry_wrap(qry_wrap), .hit_vec(hit_vec),
  .lap0_mask(lap0_mask), .lap1_mask(lap1_mask),
  .young_vld(young_vld), .young_idx(young_idx)
);

// File: tb/sq_lap_range_tb.sv
`timescale 1ns/1ps
module sq_lap_range_tb;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] deq_idx = '0, qry_idx = '0;
  logic deq_wrap = 1'b0, qry_wrap = 1'b0;
  logic [N-1:0] hit_vec = '0;
  logic [N-1:0] r_m0, r_m1, c_m0, c_m1;
  logic r_v, c_v;
  logic [IW-1:0] r_i, c_i;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  sq_lap_range #(.N(N), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .deq_idx(deq_idx), .deq_wrap(deq_wrap),
    .qry_idx(qry_idx), .qry_wrap(qry_wrap), .hit_vec(hit_vec),
    .lap0_mask(r_m0), .lap1_mask(r_m1), .young_vld(r_v), .young_idx(r_i));

  sq_lap_range #(.N(N), .REG_OUT(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .deq_idx(deq_idx), .deq_wrap(deq_wrap),
    .qry_idx(qry_idx), .qry_wrap(qry_wrap), .hit_vec(hit_vec),
    .lap0_mask(c_m0), .lap1_mask(c_m1), .young_vld(c_v), .young_idx(c_i));

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] exp_masks(input int d, input int q, input bit dw, input bit qw);
    logic [N-1:0] a, b;
    a = '0; b = '0;
    for (int i = 0; i < N; i++) begin
      if (dw == qw) a[i] = (i >= d) && (i < q);
      else begin
        a[i] = i >= d;
        b[i] = i < q;
      end
    end
    return {b, a};
  endfunction

  function automatic int exp_young(input logic [N-1:0] h, input logic [2*N-1:0] m);
    int r0, r1;
    r0 = -1; r1 = -1;
    for (int i = 0; i < N; i++) begin
      if (h[i] && m[i])   r0 = i;
      if (h[i] && m[N+i]) r1 = i;
    end
    return (r1 >= 0) ? r1 : r0;
  endfunction

  task automatic apply(input int d, input bit dw, input int q, input bit qw, input logic [N-1:0] h);
    logic [2*N-1:0] m;
    int y;
    string tg, yt;
    @(negedge clk);
    deq_idx = IW'(d); deq_wrap = dw; qry_idx = IW'(q); qry_wrap = qw; hit_vec = h;
    m = exp_masks(d, q, dw, qw);
    y = exp_young(h, m);
    tg = (dw != qw) ? "R3" : ((d == q) ? "R2" : "R1");
    yt = (y >= 0 && m[N+y]) ? "R5" : "R6";
    #1;
    check(tg, "lap0", int'(c_m0), int'(m[N-1:0]));
    check(tg, "lap1", int'(c_m1), int'(m[2*N-1:N]));
    check("R4", "vld", int'(c_v), int'(y >= 0));
    if (y >= 0) check(yt, "idx", int'(c_i), y);
    @(posedge clk); #1;
    check("R7", "reg lap0", int'(r_m0), int'(m[N-1:0]));
    check("R7", "reg lap1", int'(r_m1), int'(m[2*N-1:N]));
    check("R7", "reg vld", int'(r_v), int'(y >= 0));
    if (y >= 0) check("R7", "reg idx", int'(r_i), y);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    deq_idx = 3; qry_idx = 6; hit_vec = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R7", "reset lap0", int'(r_m0), 0);
    check("R7", "reset vld", int'(r_v), 0);
    @(negedge clk) rst_n = 1'b1;

    apply(2, 0, 6, 0, 8'b1111_1111);  // R1 plain range
    apply(4, 1, 4, 1, 8'b1111_1111);  // R2 empty
    apply(0, 0, 0, 0, 8'b0000_0001);  // R2 at zero
    apply(6, 0, 2, 1, 8'b1000_0010);  // R5 later lap beats higher index
    apply(6, 1, 2, 0, 8'b1100_0001);  // R5 flags reversed
    apply(5, 0, 3, 1, 8'b1000_1000);  // R6 hit at qry_idx is excluded
    apply(3, 0, 3, 1, 8'b0000_0100);  // R3 full queue, R5
    apply(0, 0, 7, 0, 8'b1000_0000);  // R1 upper bound exclusive, R4 invalid
    apply(7, 0, 0, 1, 8'b1000_0000);  // R3 single entry at top
    apply(5, 0, 5, 1, 8'b0000_0000);  // R4 no hits
    for (int k = 0; k < 400; k++)
      apply($urandom_range(N-1), 1'($urandom), $urandom_range(N-1), 1'($urandom),
            N'($urandom) | N'($urandom));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule